// File: doc/BRIEF.md
# Sparse-Opcode Instruction Decoder

This block decodes a 32-bit instruction word in a single combinational step. The top six bits carry an operation code. The decoder turns that code into the strobes a simple in-order core needs: an ALU operation, the read and write register indices, a register write enable, memory read and write enables, a branch condition select and a jump request. It also passes through the 5-bit shift amount and the 16-bit immediate.

The valid operation codes sit sparsely in the 64-entry code space. Any two of them differ in at least two bit positions. A single flipped bit in a fetched opcode therefore always lands on an unassigned code. The decoder does not guess at such a code. It raises an illegal-operation output and blocks every side effect.

The surrounding core reads the strobes in the same cycle the instruction word is presented. The register file, ALU and memory are outside this block.

Top module: `opsparse_decoder`

## Requirements
- R1: The field outputs are plain extracts of the instruction word, for every opcode: srcAIdx = bits 25:21, srcBIdx = bits 20:16, shiftAmt = bits 10:6, imm16 = bits 15:0.
- R2: ALU-class opcodes drive aluOp and write register rd (dstIdx = bits 15:11, regWrEn = 1). The aluOp codes are: ADD 111100→1, ADDU 001100→2, SUB 111010→3, SUBU 001010→4, AND 101000→5, OR 100111→6, XOR 100100→7, SLL 110011→8, SLLV 110000→9, SRL→10, SRLV→11, SRA 101110→12.
- R3: Both codes assigned to logical right shift by immediate (110110 and 101101) give aluOp 10. Both codes assigned to logical right shift by register (110101 and 101011) give aluOp 11.
- R4: useShamt is 1 only for the immediate shifts (aluOp 8, 10, 12). It is 0 for the register-amount shifts and for every other opcode.
- R5: Branch opcodes set immFmt = 1, leave all writes, memory and jump at 0, and set branchSel as follows: 010001 always→1, 100010 zero set→2, 011110 zero clear→3, 100001 overflow set→4, 011101 negative set→5, 010111 negative clear→6, 011011 random→7. All other opcodes give branchSel 0.
- R6: The register jump 011000 sets jumpEn = 1 and writes nothing. Its target comes from srcAIdx.
- R7: The load-low-immediate 010100 sets immFmt = 1 and aluOp 13, and writes register rt (dstIdx = bits 20:16).
- R8: The load 010010 sets memRdEn = 1 and writes rd, with the address in rs. The store 001111 sets memWrEn = 1 and writes no register.
- R9: The no-operation code 111111 is legal. It asserts no strobe and gives aluOp 0.
- R10: Any of the 38 unassigned codes sets illegalOp = 1 and forces regWrEn, memRdEn, memWrEn, jumpEn, immFmt, useShamt, aluOp and branchSel to 0. This covers every single-bit corruption of a valid code.
- R11: A register write whose destination index is 0 is suppressed (regWrEn = 0).
- R12: At most one of memory read, memory write, jump and branch is active for any word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instrWord | input | 32 | Instruction word to decode |
| aluOp | output | 4 | ALU operation code (0 = none) |
| srcAIdx | output | 5 | First read register index |
| srcBIdx | output | 5 | Second read register index |
| dstIdx | output | 5 | Write register index |
| regWrEn | output | 1 | Register write enable |
| memRdEn | output | 1 | Memory read enable |
| memWrEn | output | 1 | Memory write enable |
| branchSel | output | 3 | Branch condition select (0 = none) |
| jumpEn | output | 1 | Register-indirect jump request |
| immFmt | output | 1 | Word uses the 16-bit immediate form |
| useShamt | output | 1 | ALU takes its shift amount from shiftAmt |
| shiftAmt | output | 5 | 5-bit shift amount field |
| imm16 | output | 16 | 16-bit immediate field |
| illegalOp | output | 1 | Opcode is not assigned |

## Verification
The bench builds the decoder with its default parameters: a 32-bit word, 5-bit register indices and the zero register hardwired. With these values the opcode space is small enough to sweep in full. All 64 codes are checked for legality, and every single-bit flip of every assigned code is shown to decode as illegal. Hardwiring the zero register also brings the write-suppression path into reach, for both rd and rt destinations.

// File: rtl/opsparse_pkg.sv
package opsparse_pkg;

  localparam int OPC_W = 6;

  typedef enum logic [3:0] {
    ALU_NONE = 4'd0, ALU_ADD = 4'd1, ALU_ADDU = 4'd2, ALU_SUB = 4'd3,
    ALU_SUBU = 4'd4, ALU_AND = 4'd5, ALU_OR = 4'd6, ALU_XOR = 4'd7,
    ALU_SLL = 4'd8, ALU_SLLV = 4'd9, ALU_SRL = 4'd10, ALU_SRLV = 4'd11,
    ALU_SRA = 4'd12, ALU_LDLO = 4'd13
  } aluOp_e;

  typedef enum logic [2:0] {
    BRC_NONE = 3'd0, BRC_ALWAYS = 3'd1, BRC_ZSET = 3'd2, BRC_ZCLR = 3'd3,
    BRC_OSET = 3'd4, BRC_NSET = 3'd5, BRC_NCLR = 3'd6, BRC_RAND = 3'd7
  } brSel_e;

  typedef struct packed {
    aluOp_e alu;
    brSel_e br;
    logic   regWrite;
    logic   dstIsRt;
    logic   memRead;
    logic   memWrite;
    logic   jump;
    logic   immFmt;
    logic   useShamt;
    logic   illegal;
  } ctrlStrb_t;

  localparam logic [OPC_W-1:0] OPC_NOP   = 6'b111111;
  localparam logic [OPC_W-1:0] OPC_ADD   = 6'b111100;
  localparam logic [OPC_W-1:0] OPC_ADDU  = 6'b001100;
  localparam logic [OPC_W-1:0] OPC_SUB   = 6'b111010;
  localparam logic [OPC_W-1:0] OPC_SUBU  = 6'b001010;
  localparam logic [OPC_W-1:0] OPC_SRLA  = 6'b110110;
  localparam logic [OPC_W-1:0] OPC_SRLB  = 6'b101101;
  localparam logic [OPC_W-1:0] OPC_SRLVA = 6'b110101;
  localparam logic [OPC_W-1:0] OPC_SRLVB = 6'b101011;
  localparam logic [OPC_W-1:0] OPC_SLL   = 6'b110011;
  localparam logic [OPC_W-1:0] OPC_SLLV  = 6'b110000;
  localparam logic [OPC_W-1:0] OPC_SRA   = 6'b101110;
  localparam logic [OPC_W-1:0] OPC_AND   = 6'b101000;
  localparam logic [OPC_W-1:0] OPC_OR    = 6'b100111;
  localparam logic [OPC_W-1:0] OPC_XOR   = 6'b100100;
  localparam logic [OPC_W-1:0] OPC_BRA   = 6'b010001;
  localparam logic [OPC_W-1:0] OPC_BNCL  = 6'b010111;
  localparam logic [OPC_W-1:0] OPC_BZST  = 6'b100010;
  localparam logic [OPC_W-1:0] OPC_BOST  = 6'b100001;
  localparam logic [OPC_W-1:0] OPC_BNST  = 6'b011101;
  localparam logic [OPC_W-1:0] OPC_BZCL  = 6'b011110;
  localparam logic [OPC_W-1:0] OPC_BRND  = 6'b011011;
  localparam logic [OPC_W-1:0] OPC_JREG  = 6'b011000;
  localparam logic [OPC_W-1:0] OPC_LDLO  = 6'b010100;
  localparam logic [OPC_W-1:0] OPC_LOAD  = 6'b010010;
  localparam logic [OPC_W-1:0] OPC_STORE = 6'b001111;

endpackage

// File: rtl/opsparse_ctrl.sv
module opsparse_ctrl
  import opsparse_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  output ctrlStrb_t        strb
);

  always_comb begin
    strb = '0;
    unique case (opcode)
      OPC_NOP:   ;
      OPC_ADD:   begin strb.alu = ALU_ADD;  strb.regWrite = 1'b1; end
      OPC_ADDU:  begin strb.alu = ALU_ADDU; strb.regWrite = 1'b1; end
      OPC_SUB:   begin strb.alu = ALU_SUB;  strb.regWrite = 1'b1; end
      OPC_SUBU:  begin strb.alu = ALU_SUBU; strb.regWrite = 1'b1; end
      OPC_AND:   begin strb.alu = ALU_AND;  strb.regWrite = 1'b1; end
      OPC_OR:    begin strb.alu = ALU_OR;   strb.regWrite = 1'b1; end
      OPC_XOR:   begin strb.alu = ALU_XOR;  strb.regWrite = 1'b1; end
      OPC_SLLV:  begin strb.alu = ALU_SLLV; strb.regWrite = 1'b1; end
      OPC_SRLVA,
      OPC_SRLVB: begin strb.alu = ALU_SRLV; strb.regWrite = 1'b1; end
      OPC_SLL:   begin strb.alu = ALU_SLL;  strb.regWrite = 1'b1; strb.useShamt = 1'b1; end
      OPC_SRLA,
      OPC_SRLB:  begin strb.alu = ALU_SRL;  strb.regWrite = 1'b1; strb.useShamt = 1'b1; end
      OPC_SRA:   begin strb.alu = ALU_SRA;  strb.regWrite = 1'b1; strb.useShamt = 1'b1; end
      OPC_LDLO:  begin
        strb.alu = ALU_LDLO; strb.regWrite = 1'b1;
        strb.dstIsRt = 1'b1; strb.immFmt = 1'b1;
      end
      OPC_LOAD:  begin strb.memRead = 1'b1; strb.regWrite = 1'b1; end
      OPC_STORE: strb.memWrite = 1'b1;
      OPC_JREG:  strb.jump = 1'b1;
      OPC_BRA:   begin strb.br = BRC_ALWAYS; strb.immFmt = 1'b1; end
      OPC_BZST:  begin strb.br = BRC_ZSET;   strb.immFmt = 1'b1; end
      OPC_BZCL:  begin strb.br = BRC_ZCLR;   strb.immFmt = 1'b1; end
      OPC_BOST:  begin strb.br = BRC_OSET;   strb.immFmt = 1'b1; end
      OPC_BNST:  begin strb.br = BRC_NSET;   strb.immFmt = 1'b1; end
      OPC_BNCL:  begin strb.br = BRC_NCLR;   strb.immFmt = 1'b1; end
      OPC_BRND:  begin strb.br = BRC_RAND;   strb.immFmt = 1'b1; end
      default:   strb.illegal = 1'b1;
    endcase
  end

  // Guards on the strobe set leaving the control path
  always_comb begin
    assert_illegal_quiet_R10: assert (!strb.illegal ||
      (!strb.regWrite && !strb.memRead && !strb.memWrite && !strb.jump &&
       strb.br == BRC_NONE && strb.alu == ALU_NONE))
      else $error("illegal opcode left a strobe active");
    assert_single_effect_R12: assert ($onehot0({strb.memRead, strb.memWrite,
      strb.jump, strb.br != BRC_NONE}))
      else $error("more than one side effect selected");
    assert_shamt_not_imm_R4: assert (!(strb.useShamt && strb.immFmt))
      else $error("shift amount and 16-bit immediate both selected");
  end

endmodule

// File: rtl/opsparse_datapath.sv
module opsparse_datapath
  import opsparse_pkg::*;
#(
  parameter int INSTR_W   = 32,
  parameter int REG_W     = 5,
  parameter int SHAMT_W   = 5,
  parameter int IMM_W     = 16,
  parameter bit ZERO_HARD = 1'b1
) (
  input  logic [INSTR_W-1:0] instrWord,
  input  ctrlStrb_t          strb,
  output logic [REG_W-1:0]   srcAIdx,
  output logic [REG_W-1:0]   srcBIdx,
  output logic [REG_W-1:0]   dstIdx,
  output logic               regWrEn,
  output logic               memRdEn,
  output logic               memWrEn,
  output logic [SHAMT_W-1:0] shiftAmt,
  output logic [IMM_W-1:0]   imm16
);

  localparam int OP_LSB = INSTR_W - OPC_W;
  localparam int RS_LSB = OP_LSB - REG_W;
  localparam int RT_LSB = RS_LSB - REG_W;
  localparam int RD_LSB = RT_LSB - REG_W;
  localparam int SH_LSB = RD_LSB - SHAMT_W;

  logic [REG_W-1:0] rdField;
  logic             wantWrite;

  assign srcAIdx  = instrWord[RS_LSB +: REG_W];
  assign srcBIdx  = instrWord[RT_LSB +: REG_W];
  assign rdField  = instrWord[RD_LSB +: REG_W];
  assign shiftAmt = instrWord[SH_LSB +: SHAMT_W];
  assign imm16    = instrWord[IMM_W-1:0];

  assign dstIdx    = strb.dstIsRt ? srcBIdx : rdField;
  assign wantWrite = strb.regWrite && !strb.illegal;
  assign memRdEn   = strb.memRead && !strb.illegal;
  assign memWrEn   = strb.memWrite && !strb.illegal;

  generate
    if (ZERO_HARD) begin : g_zeroHard
      assign regWrEn = wantWrite && (dstIdx != '0);
    end else begin : g_zeroSoft
      assign regWrEn = wantWrite;
    end
  endgenerate

  always_comb begin
    if (ZERO_HARD) begin
      assert_zero_reg_kept_R11: assert (!(regWrEn && dstIdx == '0))
        else $error("write to register zero enabled");
    end
    assert_store_no_regwr_R8: assert (!(memWrEn && regWrEn))
      else $error("store also writes a register");
  end

endmodule

// File: rtl/opsparse_decoder.sv
module opsparse_decoder
  import opsparse_pkg::*;
#(
  parameter int INSTR_W   = 32,
  parameter int REG_W     = 5,
  parameter int SHAMT_W   = 5,
  parameter int IMM_W     = 16,
  parameter bit ZERO_HARD = 1'b1
) (
  input  logic [INSTR_W-1:0] instrWord,
  output logic [3:0]         aluOp,
  output logic [REG_W-1:0]   srcAIdx,
  output logic [REG_W-1:0]   srcBIdx,
  output logic [REG_W-1:0]   dstIdx,
  output logic               regWrEn,
  output logic               memRdEn,
  output logic               memWrEn,
  output logic [2:0]         branchSel,
  output logic               jumpEn,
  output logic               immFmt,
  output logic               useShamt,
  output logic [SHAMT_W-1:0] shiftAmt,
  output logic [IMM_W-1:0]   imm16,
  output logic               illegalOp
);

  ctrlStrb_t strb;

  opsparse_ctrl u_ctrl (
    .opcode (instrWord[INSTR_W-1 -: OPC_W]),
    .strb   (strb)
  );

  opsparse_datapath #(
    .INSTR_W   (INSTR_W),
    .REG_W     (REG_W),
    .SHAMT_W   (SHAMT_W),
    .IMM_W     (IMM_W),
    .ZERO_HARD (ZERO_HARD)
  ) u_dp (
    .instrWord (instrWord),
    .strb      (strb),
    .srcAIdx   (srcAIdx),
    .srcBIdx   (srcBIdx),
    .dstIdx    (dstIdx),
    .regWrEn   (regWrEn),
    .memRdEn   (memRdEn),
    .memWrEn   (memWrEn),
    .shiftAmt  (shiftAmt),
    .imm16     (imm16)
  );

  assign aluOp     = strb.alu;
  assign branchSel = strb.br;
  assign jumpEn    = strb.jump;
  assign immFmt    = strb.immFmt;
  assign useShamt  = strb.useShamt;
  assign illegalOp = strb.illegal;

  always_comb begin
    assert_illegal_blocks_mem_R10: assert (!(illegalOp && (memRdEn || memWrEn || regWrEn)))
      else $error("illegal opcode reached a write or read port");
  end

endmodule

// File: tb/opsparse_decoder_bench.sv
`timescale 1ns/1ps
module opsparse_decoder_bench;

  logic        clk = 1'b0;
  logic [31:0] instrWord;
  logic [3:0]  aluOp;
  logic [4:0]  srcAIdx, srcBIdx, dstIdx, shiftAmt;
  logic        regWrEn, memRdEn, memWrEn, jumpEn, immFmt, useShamt, illegalOp;
  logic [2:0]  branchSel;
  logic [15:0] imm16;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  opsparse_decoder u_opsparse_decoder (
    .instrWord (instrWord), .aluOp (aluOp), .srcAIdx (srcAIdx), .srcBIdx (srcBIdx),
    .dstIdx (dstIdx), .regWrEn (regWrEn), .memRdEn (memRdEn), .memWrEn (memWrEn),
    .branchSel (branchSel), .jumpEn (jumpEn), .immFmt (immFmt), .useShamt (useShamt),
    .shiftAmt (shiftAmt), .imm16 (imm16), .illegalOp (illegalOp)
  );

  // {opcode[6], aluOp[4], branchSel[3], dstIsRt[1], flags[7]}
  // flags = {regWr, memRd, memWr, jump, immFmt, useShamt, illegal}
  localparam int NV = 26;
  localparam logic [20:0] VEC [NV] = '{
    {6'b111111, 4'd0,  3'd0, 1'b0, 7'b0000000},
    {6'b111100, 4'd1,  3'd0, 1'b0, 7'b1000000},
    {6'b001100, 4'd2,  3'd0, 1'b0, 7'b1000000},
    {6'b111010, 4'd3,  3'd0, 1'b0, 7'b1000000},
    {6'b001010, 4'd4,  3'd0, 1'b0, 7'b1000000},
    {6'b101000, 4'd5,  3'd0, 1'b0, 7'b1000000},
    {6'b100111, 4'd6,  3'd0, 1'b0, 7'b1000000},
    {6'b100100, 4'd7,  3'd0, 1'b0, 7'b1000000},
    {6'b110011, 4'd8,  3'd0, 1'b0, 7'b1000010},
    {6'b110000, 4'd9,  3'd0, 1'b0, 7'b1000000},
    {6'b110110, 4'd10, 3'd0, 1'b0, 7'b1000010},
    {6'b101101, 4'd10, 3'd0, 1'b0, 7'b1000010},
    {6'b110101, 4'd11, 3'd0, 1'b0, 7'b1000000},
    {6'b101011, 4'd11, 3'd0, 1'b0, 7'b1000000},
    {6'b101110, 4'd12, 3'd0, 1'b0, 7'b1000010},
    {6'b010100, 4'd13, 3'd0, 1'b1, 7'b1000100},
    {6'b010010, 4'd0,  3'd0, 1'b0, 7'b1100000},
    {6'b001111, 4'd0,  3'd0, 1'b0, 7'b0010000},
    {6'b011000, 4'd0,  3'd0, 1'b0, 7'b0001000},
    {6'b010001, 4'd0,  3'd1, 1'b0, 7'b0000100},
    {6'b100010, 4'd0,  3'd2, 1'b0, 7'b0000100},
    {6'b011110, 4'd0,  3'd3, 1'b0, 7'b0000100},
    {6'b100001, 4'd0,  3'd4, 1'b0, 7'b0000100},
    {6'b011101, 4'd0,  3'd5, 1'b0, 7'b0000100},
    {6'b010111, 4'd0,  3'd6, 1'b0, 7'b0000100},
    {6'b011011, 4'd0,  3'd7, 1'b0, 7'b0000100}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (instr 0x%08h)", req, act, exp, instrWord);
    end
  endtask

  task automatic apply(input logic [31:0] w);
    @(negedge clk);
    instrWord = w;
    @(posedge clk);
    #1;
  endtask

  function automatic logic [6:0] flagsNow();
    return {regWrEn, memRdEn, memWrEn, jumpEn, immFmt, useShamt, illegalOp};
  endfunction

  function automatic bit isValid(input logic [5:0] op);
    for (int k = 0; k < NV; k++) if (VEC[k][20:15] == op) return 1'b1;
    return 1'b0;
  endfunction

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    instrWord = 32'h0;
    // Start state: all-zero word is an unassigned code (R10)
    apply(32'h0000_0000);
    chk("R10 zero word illegal", {31'b0, illegalOp}, 32'd1);
    chk("R10 zero word quiet", {25'b0, flagsNow()}, 32'h01);

    // Table walk: rs=3, rt=5, rd=9, shamt=17, rest of word patterned
    for (int i = 0; i < NV; i++) begin
      logic [31:0] w;
      w = {VEC[i][20:15], 5'd3, 5'd5, 5'd9, 5'd17, 6'h2a};
      apply(w);
      chk("R2/R3/R7 aluOp", {28'b0, aluOp}, {28'b0, VEC[i][14:11]});
      chk("R5 branchSel", {29'b0, branchSel}, {29'b0, VEC[i][10:8]});
      chk("R4/R6/R8/R9 strobes", {25'b0, flagsNow()}, {25'b0, VEC[i][6:0]});
      if (VEC[i][6]) chk("R2/R7 dstIdx", {27'b0, dstIdx}, VEC[i][7] ? 32'd5 : 32'd9);
    end

    // R1: field extraction under distinct patterns
    begin
      logic [31:0] pats [4] = '{32'hF3A5_C3B7, 32'h4BFF_0001, 32'h2A5A_A55A, 32'h5000_FFFF};
      for (int i = 0; i < 4; i++) begin
        apply(pats[i]);
        chk("R1 srcAIdx", {27'b0, srcAIdx}, {27'b0, pats[i][25:21]});
        chk("R1 srcBIdx", {27'b0, srcBIdx}, {27'b0, pats[i][20:16]});
        chk("R1 shiftAmt", {27'b0, shiftAmt}, {27'b0, pats[i][10:6]});
        chk("R1 imm16", {16'b0, imm16}, {16'b0, pats[i][15:0]});
      end
    end

    // R11: destination zero suppressed for rd and rt writers
    apply({6'b111100, 5'd4, 5'd6, 5'd0, 11'd0});
    chk("R11 add to r0", {31'b0, regWrEn}, 32'd0);
    apply({6'b110110, 5'd0, 5'd7, 5'd0, 5'd3, 6'd0});
    chk("R11 srl to r0", {31'b0, regWrEn}, 32'd0);
    apply({6'b010100, 5'd0, 5'd0, 16'h1234});
    chk("R11 lli to r0", {31'b0, regWrEn}, 32'd0);
    apply({6'b010100, 5'd0, 5'd1, 16'h1234});
    chk("R11 lli to r1", {31'b0, regWrEn}, 32'd1);
    apply({6'b010010, 5'd8, 5'd0, 5'd0, 11'd0});
    chk("R11 load to r0", {31'b0, regWrEn}, 32'd0);
    chk("R8 load still reads", {31'b0, memRdEn}, 32'd1);

    // R10: full sweep of the opcode space
    for (int op = 0; op < 64; op++) begin
      bit v;
      v = isValid(op[5:0]);
      apply({op[5:0], 5'd2, 5'd3, 5'd4, 11'h7ff});
      chk("R10 legality", {31'b0, illegalOp}, {31'b0, !v});
      if (!v) begin
        chk("R10 illegal quiet", {21'b0, aluOp, branchSel, flagsNow()}, 32'h1);
      end
      chk("R12 single effect", {31'b0, $onehot0({memRdEn, memWrEn, jumpEn, branchSel != 3'd0})}, 32'd1);
    end

    // R10: every single-bit flip of every assigned code is illegal
    for (int i = 0; i < NV; i++) begin
      for (int b = 0; b < 6; b++) begin
        logic [5:0] op;
        op = VEC[i][20:15] ^ (6'd1 << b);
        apply({op, 5'd1, 5'd2, 5'd3, 11'd0});
        chk("R10 single-bit flip", {31'b0, illegalOp}, 32'd1);
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule